// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose data bus can switch between reads and writes on consecutive clocks with no idle cycle in between. Commands (address, select, write strobe, byte enables) are sampled on the rising clock edge. The write data for a command is taken late, in the same bus slot that read data would occupy. As a result, any mix of reads and writes keeps the bus fully used.

A static mode input picks one of two read paths. In flow-through mode the storage array is read combinationally, and the data is on the bus in the cycle after the command edge. In pipelined mode an output register adds one cycle. Write data follows the same slot: one edge after the command in flow-through mode and two edges after it in pipelined mode.

The block has three chip selects, a clock-enable stall, per-byte write enables over 9-bit bytes with parity checking, an asynchronous output enable and an asynchronous sleep input. Bursting is done outside the block: in a continue cycle the external burst logic supplies the next address, and the block repeats the type of the previous cycle. The tri-state bus is represented as a data vector plus a drive flag, and the data vector reads zero whenever the drive flag is low. The mode input is meant to be changed only while reset is held.

Top module: `zt_sram`

## Requirements
- R1: A new cycle starts on an enabled edge with `start_n` low. It is a read (`wr_n` high) or a write (`wr_n` low) only when `sel1_n` is low, `sel2` is high and `sel3_n` is low. Any other select combination gives a deselect cycle: nothing is driven and no memory is written.
- R2: With `pipe_mode` = 0, a read command makes `rd_drive` high and puts the word on `rd_data` in the cycle after its command edge.
- R3: With `pipe_mode` = 1, the read word appears one cycle later than in R2, that is, after the second enabled edge.
- R4: Write data is sampled from `wr_data` on the first enabled edge after the command when `pipe_mode` = 0, and on the second when `pipe_mode` = 1. Read and write commands may alternate on every cycle, and each read returns the data of all earlier commands.
- R5: Byte i occupies bits [9i+8:9i] and is written only when `byte_wr_n[i]` is low. A write with every `byte_wr_n` bit high changes no memory.
- R6: An enabled edge with `start_n` high is a continue cycle. It ignores the selects and repeats the previous cycle type (read, write or deselect) at the address on `addr`. A continue cycle that follows a deselect stays deselected.
- R7: While `clk_en_n` is high, clock edges are ignored and all state holds. A read already on the bus keeps driving it, and a stalled write data slot stays undriven.
- R8: `out_en_n` high turns `rd_drive` off in the same cycle. A read issued or shown under it still advances the pipeline (dummy read).
- R9: `rd_drive` is low in every write data slot, even with `out_en_n` low.
- R10: While `sleep` is high, `rd_drive` is low and clock edges are ignored. A write command issued during sleep writes nothing.
- R11: The cycle after a reset edge shows `rd_drive` low and `par_err` low.
- R12: In pipelined mode, a read issued right after a write to the same address returns the new bytes of that write merged over the stored bytes.
- R13: Bit 8 of each byte is parity. With `par_odd` = 0 the XOR of all nine bits must be 0, and with `par_odd` = 1 it must be 1. A mismatch in an enabled byte at its data edge sets `par_err` one cycle later. `par_err` then stays set until reset. Disabled bytes are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| clk_en_n | input | 1 | Active-low clock enable; high stalls |
| start_n | input | 1 | Low starts a new cycle, high continues |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Low = write, high = read |
| byte_wr_n | input | NBYTES | Active-low byte write enables |
| addr | input | ADDR_W | Word address |
| wr_data | input | NBYTES*9 | Late write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_data | output | NBYTES*9 | Read data, zero when not driven |
| rd_drive | output | 1 | Bus drive enable |
| par_err | output | 1 | Sticky parity error |

## Verification
The bench numbers every bus slot. For each command it stores the expected bus state against the slot where that state is due. Flow-through read data and write data slots fall one slot after the command, and pipelined ones two slots after. The parity flag is due one slot after the data slot, and stalls, sleep or a late output-enable change move or hold these results as R7, R8 and R10 describe. A monitor samples one nanosecond before each rising edge and compares only the entries stamped for that slot. Inputs change at the falling edge, so every result is taken after all registers on its path have settled.

// File: rtl/zts_pkg.sv
`timescale 1ns/1ps
package zts_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // True when a 9-bit byte fails the selected parity sense.
    function automatic logic par_bad(input logic [BYTE_W-1:0] b, input logic odd);
        return (^b) != odd;
    endfunction
endpackage

// File: rtl/zts_decode.sv
`timescale 1ns/1ps
module zts_decode
    import zts_pkg::*;
(
    input  logic     start_n,
    input  logic     sel1_n,
    input  logic     sel2,
    input  logic     sel3_n,
    input  logic     wr_n,
    input  op_kind_e prev_kind,
    output op_kind_e kind
);
    logic chosen;

    always_comb begin
        chosen = !sel1_n && sel2 && !sel3_n;
        if (start_n)
            kind = prev_kind;          // continue: same type as last cycle
        else if (!chosen)
            kind = OP_NONE;            // deselect
        else if (wr_n)
            kind = OP_READ;
        else
            kind = OP_WRITE;
    end
endmodule

// File: rtl/zts_array.sv
`timescale 1ns/1ps
module zts_array
    import zts_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be_n,
    input  logic [NBYTES*BYTE_W-1:0] wr_word,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (!wr_be_n[b])
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_word[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/zts_parity.sv
`timescale 1ns/1ps
module zts_parity
    import zts_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     chk_en,
    input  logic [NBYTES-1:0]        be_n,
    input  logic [NBYTES*BYTE_W-1:0] word,
    input  logic                     odd,
    output logic                     err
);
    logic [NBYTES-1:0] bad;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign bad[g] = chk_en && !be_n[g] && par_bad(word[g*BYTE_W +: BYTE_W], odd);
    end

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (|bad)
            err <= 1'b1;
    end

    a_r13_sticky_flag: assert property (@(posedge clk) disable iff (rst) err |=> err);
endmodule

// File: rtl/zts_out_stage.sv
`timescale 1ns/1ps
module zts_out_stage
    import zts_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv_en,
    input  logic                     pipe_mode,
    input  logic                     rd_now,
    input  logic [NBYTES*BYTE_W-1:0] arr_word,
    input  logic                     byp_en,
    input  logic [NBYTES-1:0]        byp_be_n,
    input  logic [NBYTES*BYTE_W-1:0] byp_word,
    input  logic                     out_en_n,
    input  logic                     sleep,
    output logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     rd_drive
);
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] q_word;
    logic              q_vld;
    logic [DATA_W-1:0] src_word;
    logic              src_vld;

    // Late-write bypass: bytes arriving at this edge for the same address win.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byp
        assign merged[g*BYTE_W +: BYTE_W] = (byp_en && !byp_be_n[g])
                                          ? byp_word[g*BYTE_W +: BYTE_W]
                                          : arr_word[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_word <= '0;
        end else if (adv_en) begin
            q_vld <= rd_now;
            if (rd_now)
                q_word <= merged;
        end
    end

    always_comb begin
        src_vld  = pipe_mode ? q_vld  : rd_now;
        src_word = pipe_mode ? q_word : arr_word;
        rd_drive = src_vld && !out_en_n && !sleep;
        rd_data  = rd_drive ? src_word : '0;
    end

    a_r11_quiet_after_reset: assert property (@(posedge clk) $past(rst) |-> !rd_drive);
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zts_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pipe_mode,
    input  logic                     clk_en_n,
    input  logic                     start_n,
    input  logic                     sel1_n,
    input  logic                     sel2,
    input  logic                     sel3_n,
    input  logic                     wr_n,
    input  logic [NBYTES-1:0]        byte_wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic                     out_en_n,
    input  logic                     sleep,
    input  logic                     par_odd,
    output logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     rd_drive,
    output logic                     par_err
);
    localparam int DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        op_kind_e            kind;
        logic [ADDR_W-1:0]   addr;
        logic [NBYTES-1:0]   be_n;
    } slot_t;

    slot_t    st_a;     // command taken at the last enabled edge
    slot_t    st_b;     // command taken one enabled edge earlier
    slot_t    wslot;    // command whose data slot ends at the next edge
    op_kind_e dec_kind;
    logic     adv_en;
    logic     wr_fire;
    logic     byp_en;
    logic [DATA_W-1:0] arr_word;

    assign adv_en = !clk_en_n && !sleep;

    zts_decode u_decode (
        .start_n   (start_n),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .wr_n      (wr_n),
        .prev_kind (st_a.kind),
        .kind      (dec_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_a <= '{kind: OP_NONE, addr: '0, be_n: '1};
            st_b <= '{kind: OP_NONE, addr: '0, be_n: '1};
        end else if (adv_en) begin
            st_a <= '{kind: dec_kind, addr: addr, be_n: byte_wr_n};
            st_b <= st_a;
        end
    end

    assign wslot   = pipe_mode ? st_b : st_a;
    assign wr_fire = !rst && adv_en && (wslot.kind == OP_WRITE);
    assign byp_en  = pipe_mode && (st_b.kind == OP_WRITE) && (st_b.addr == st_a.addr);

    zts_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_array (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_addr (wslot.addr),
        .wr_be_n (wslot.be_n),
        .wr_word (wr_data),
        .rd_addr (st_a.addr),
        .rd_word (arr_word)
    );

    zts_out_stage #(.NBYTES(NBYTES)) u_out (
        .clk       (clk),
        .rst       (rst),
        .adv_en    (adv_en),
        .pipe_mode (pipe_mode),
        .rd_now    (st_a.kind == OP_READ),
        .arr_word  (arr_word),
        .byp_en    (byp_en),
        .byp_be_n  (st_b.be_n),
        .byp_word  (wr_data),
        .out_en_n  (out_en_n),
        .sleep     (sleep),
        .rd_data   (rd_data),
        .rd_drive  (rd_drive)
    );

    zts_parity #(.NBYTES(NBYTES)) u_parity (
        .clk    (clk),
        .rst    (rst),
        .chk_en (wr_fire),
        .be_n   (wslot.be_n),
        .word   (wr_data),
        .odd    (par_odd),
        .err    (par_err)
    );

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(st_a) && $stable(st_b)));

    a_r9_write_slot_quiet: assert property (@(posedge clk) disable iff (rst)
        (wslot.kind == OP_WRITE) |-> !rd_drive);

    a_r3_pipe_read_shows: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && adv_en && st_a.kind == OP_READ) |=> (rd_drive || out_en_n || sleep));
endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
    import zts_pkg::*;

    localparam int AW = 4;
    localparam int NB = 4;
    localparam int DW = NB * 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic pipe_mode = 1'b0, clk_en_n = 1'b0, start_n = 1'b0;
    logic sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0, wr_n = 1'b1;
    logic [NB-1:0] byte_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic out_en_n = 1'b0, sleep = 1'b0, par_odd = 1'b0;
    logic [DW-1:0] rd_data;
    logic rd_drive, par_err;

    zt_sram #(.ADDR_W(AW), .NBYTES(NB)) dut_i (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .clk_en_n(clk_en_n),
        .start_n(start_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .wr_n(wr_n), .byte_wr_n(byte_wr_n), .addr(addr), .wr_data(wr_data),
        .out_en_n(out_en_n), .sleep(sleep), .par_odd(par_odd),
        .rd_data(rd_data), .rd_drive(rd_drive), .par_err(par_err)
    );

    typedef struct {
        int          cyc;
        int          kind;   // 0 = bus, 1 = parity flag
        logic        drive;
        logic [DW-1:0] data;
        string       req;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] plan [int];
    logic [DW-1:0] refm [16];
    int cyc = 0, n_chk = 0, n_fail = 0, lat = 1;
    logic odd = 1'b0;

    function automatic logic [DW-1:0] mkw(input int seed, input logic od);
        logic [DW-1:0] w;
        logic [7:0] v;
        for (int b = 0; b < NB; b++) begin
            v = 8'(seed * 7 + b * 53 + 11);
            w[b*9 +: 9] = {(^v) ^ od, v};
        end
        return w;
    endfunction

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [NB-1:0] ben);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++)
            if (!ben[b]) r[b*9 +: 9] = d[b*9 +: 9];
        return r;
    endfunction

    task automatic tally(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (slot %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input int k, input logic d, input logic [DW-1:0] v, input string req);
        sbq.push_back('{c, k, d, v, req});
    endtask

    // Monitor: one nanosecond before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].cyc == cyc) begin
                    if (sbq[i].kind == 0) begin
                        if (sbq[i].drive)
                            tally(rd_drive === 1'b1 && rd_data === sbq[i].data, sbq[i].req,
                                  {rd_drive, rd_data}, {1'b1, sbq[i].data});
                        else
                            tally(rd_drive === 1'b0, sbq[i].req, {rd_drive, rd_data}, '0);
                    end else begin
                        tally(par_err === sbq[i].drive, sbq[i].req,
                              {{DW{1'b0}}, par_err}, {{DW{1'b0}}, sbq[i].drive});
                    end
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic next();
        @(negedge clk);
        cyc++;
        start_n = 1'b0; sel1_n = 1'b1; sel2 = 1'b1; sel3_n = 1'b0; wr_n = 1'b1;
        byte_wr_n = '1; clk_en_n = 1'b0; out_en_n = 1'b0; sleep = 1'b0; addr = '0;
        wr_data = plan.exists(cyc) ? plan[cyc] : '0;
    endtask

    task automatic rd(input int a, input string req, input bit quiet = 0, input bit cont = 0);
        addr = AW'(a); wr_n = 1'b1;
        if (cont) start_n = 1'b1; else sel1_n = 1'b0;
        push(cyc + lat, 0, !quiet, refm[a], req);
        next();
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input logic [NB-1:0] ben,
                      input string req, input bit cont = 0);
        addr = AW'(a); wr_n = 1'b0; byte_wr_n = ben;
        if (cont) start_n = 1'b1; else sel1_n = 1'b0;
        plan[cyc + lat] = d;
        refm[a] = mrg(refm[a], d, ben);
        push(cyc + lat, 0, 1'b0, '0, req);
        next();
    endtask

    task automatic dsel(input logic s1, input logic s2, input logic s3, input logic w,
                        input int a, input string req);
        start_n = 1'b0; sel1_n = s1; sel2 = s2; sel3_n = s3; wr_n = w;
        byte_wr_n = '0; addr = AW'(a);
        plan[cyc + lat] = ~refm[a];
        push(cyc + lat, 0, 1'b0, '0, req);
        next();
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        next(); next();
        rst = 1'b0;
        push(cyc, 0, 1'b0, '0, "R11 bus off after reset");
        push(cyc, 1, 1'b0, '0, "R11 parity flag clear after reset");
        // Fill every word (flow-through)
        for (int a = 0; a < 16; a++) wr(a, mkw(a * 29 + 3, odd), '0, "R9 fill write slot quiet");

        // R2/R4 alternating read and write
        wr(3, mkw(101, odd), '0, "R4 write");
        rd(3, "R4 read after write");
        wr(4, mkw(102, odd), '0, "R9 write slot");
        rd(4, "R2 flow-through read");
        rd(3, "R2 flow-through second read");
        // R5 byte enables and abort
        wr(5, mkw(103, odd), 4'b1010, "R5 partial write");
        rd(5, "R5 partial merge");
        wr(6, mkw(104, odd), 4'b1111, "R5 abort write");
        rd(6, "R5 abort leaves word");
        // R1 deselect variants
        dsel(1'b0, 1'b0, 1'b0, 1'b1, 2, "R1 sel2 low deselects read");
        dsel(1'b0, 1'b1, 1'b1, 1'b0, 7, "R1 sel3_n high deselects write");
        rd(7, "R1 deselected write wrote nothing");
        dsel(1'b1, 1'b1, 1'b0, 1'b1, 8, "R1 sel1_n high deselects");
        // R6 continue cycles
        rd(8, "R6 read start");
        rd(9, "R6 continue read", 0, 1);
        dsel(1'b1, 1'b1, 1'b0, 1'b1, 8, "R6 deselect");
        rd(10, "R6 continue after deselect stays off", 1, 1);
        wr(11, mkw(105, odd), '0, "R6 write start");
        wr(12, mkw(106, odd), '0, "R6 continue write", 1);
        rd(12, "R6 continue write landed");
        rd(11, "R6 first write landed");
        // R8 dummy read
        rd(3, "R8 output enable off", 1);
        out_en_n = 1'b1;
        rd(4, "R8 pipeline advanced past dummy read");
        // R10 sleep
        rd(5, "R10 sleep forces bus off", 1);
        sleep = 1'b1; sel1_n = 1'b0; wr_n = 1'b0; byte_wr_n = '0; addr = '0;
        wr_data = ~refm[0];
        push(cyc + 1, 0, 1'b1, refm[5], "R10 read held across sleep");
        next(); next();
        rd(0, "R10 write during sleep ignored");
        // R7 stall on read
        rd(6, "R7 read before stall");
        clk_en_n = 1'b1; sel1_n = 1'b0; addr = 4'd9;
        push(cyc + 1, 0, 1'b1, refm[6], "R7 read still driven");
        next(); next();
        // R7 stall on write data slot
        addr = 4'd13; sel1_n = 1'b0; wr_n = 1'b0; byte_wr_n = '0;
        d = mkw(107, odd);
        refm[13] = d;
        plan[cyc + 2] = d;
        push(cyc + 1, 0, 1'b0, '0, "R7 stalled write slot off");
        push(cyc + 2, 0, 1'b0, '0, "R7 write slot after stall off");
        next();
        clk_en_n = 1'b1; wr_data = ~d;
        next(); next();
        rd(13, "R7 stalled write took later data");
        // R13 parity
        par_odd = 1'b1; odd = 1'b1;
        push(cyc + 2, 1, 1'b0, '0, "R13 odd parity clean");
        wr(14, mkw(108, odd), '0, "R13 write");
        d = mkw(109, odd); d[17] = ~d[17];
        push(cyc + 2, 1, 1'b0, '0, "R13 disabled byte not checked");
        wr(15, d, 4'b0010, "R13 write");
        d = mkw(110, odd); d[8] = ~d[8];
        push(cyc + 2, 1, 1'b1, '0, "R13 error raised");
        wr(15, d, '0, "R13 write");
        push(cyc + 2, 1, 1'b1, '0, "R13 flag sticky");
        wr(14, mkw(111, odd), '0, "R13 write");
        rd(15, "R13 bad-parity data still stored");
        next(); next(); next();

        // Pipelined mode
        rst = 1'b1; next(); next();
        pipe_mode = 1'b1; lat = 2;
        next();
        rst = 1'b0;
        push(cyc, 0, 1'b0, '0, "R11 bus off after second reset");
        push(cyc, 1, 1'b0, '0, "R11 parity flag cleared");
        next();
        wr(1, mkw(120, odd), '0, "R9 pipelined write slot");
        rd(2, "R3 pipelined read");
        wr(2, mkw(121, odd), '0, "R4 pipelined write");
        rd(1, "R3 pipelined read after write");
        rd(2, "R4 read after write");
        wr(3, mkw(122, odd), '0, "R12 write");
        rd(3, "R12 bypass full word");
        wr(4, mkw(123, odd), 4'b0110, "R12 partial write");
        rd(4, "R12 bypass merged bytes");
        rd(4, "R12 committed merged bytes");
        // R7 pipelined stall keeps driving
        rd(7, "R7 pipelined read");
        next();
        clk_en_n = 1'b1;
        push(cyc + 1, 0, 1'b1, refm[7], "R7 pipelined read held");
        next(); next();
        // R8 late output enable in pipelined mode
        rd(8, "R8 pipelined dummy read", 1);
        next();
        out_en_n = 1'b1;
        next();
        rd(9, "R3 read after dummy");
        for (int i = 0; i < 5; i++) next();
        tally(sbq.size() == 0, "scoreboard drained", DW'(sbq.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule